// File: doc/BRIEF.md
# Sequential Multi-Level Trigger Evaluator

This block decides when an embedded capture unit should start recording. On every rising edge of the acquisition clock it samples a vector of probed signals. It tests that sample against a chain of up to ten trigger stages. Each stage gives every probed signal its own 3-bit condition. A condition is either a static test (ignore, low, high) or an edge test (rising, falling, either), and edge tests compare the sample with the one taken on the previous edge. The stages are worked through in order. A stage is only looked at once every earlier stage has been met, and each stage is judged on a later sample than the stage before it. When the final configured stage is met, the block emits a one-cycle trigger pulse. It then stays latched until software-side logic re-arms it.

An external trigger input, with its own condition code, can be joined to the final stage. This lets one instance wait for another. A trigger output follows the latched trigger with a programmable polarity, so a downstream analyzer or bench instrument can be chained from it.

The FSM has three states:
- `ST_IDLE`: reset state, not armed.
- `ST_SEARCH`: armed, working through the stages.
- `ST_FIRED`: trigger latched.

Its transitions are:
- IDLE→SEARCH on `arm`.
- SEARCH→SEARCH on a stage match that is not the last stage: the stage index advances.
- SEARCH→SEARCH on `arm`: the search restarts.
- SEARCH→FIRED on a match of the last stage: `trig_pulse` is raised.
- FIRED→SEARCH on `arm`.

Every other case holds the current state.

Top module: `mlt_trigger_top`

## Requirements
- R1: The decision for a sample presented at rising edge k appears on `trig_pulse` in the cycle that follows edge k. The pulse lasts exactly one cycle.
- R2: Static condition codes per signal: 0 matches anything, 1 matches a 0, 2 matches a 1. The code for stage L and signal s sits at bits [(L*NUM_SIG+s)*3 +: 3] of `cond_cfg`. A stage matches only when all of its signals match.
- R3: Edge codes compare the current sample with the previous one: 3 matches 0→1, 4 matches 1→0, and 5 matches any change.
- R4: On the first evaluated edge after the arm edge there is no previous sample, so no edge code matches there, even if the signal changed.
- R5: Stages are evaluated in order on successive samples. Stage n+1 is only tested after stage n has matched, and a later stage's condition seen earlier is ignored.
- R6: `lvl_count` selects 1 to 10 stages. A value of 0 acts as 1, and values above 10 act as 10.
- R7: After a trigger the block produces no further pulse until `arm` is sampled high. Re-arming restarts at stage 0.
- R8: `trig_out` equals `trig_pol` from the cycle after the trigger edge until the arm edge, and its inverse at all other times.
- R9: With `ext_en`=1 the final stage also requires `ext_in` to meet `ext_cond`, using the same codes as R2/R3. With `ext_en`=0, `ext_in` has no effect.
- R10: Reserved codes 6 and 7 never match.
- R11: After reset the block is unarmed, and no trigger fires before `arm` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm / re-arm request, sampled per edge |
| probe | input | NUM_SIG | Probed signal vector |
| cond_cfg | input | MAX_LVL*NUM_SIG*3 | Per-stage per-signal condition codes |
| lvl_count | input | $clog2(MAX_LVL+1) | Number of stages in use |
| ext_en | input | 1 | Join external trigger to last stage |
| ext_in | input | 1 | External trigger input |
| ext_cond | input | 3 | Condition code for `ext_in` |
| trig_pol | input | 1 | 1 = trigger-out active high, 0 = active low |
| trig_pulse | output | 1 | Single-cycle trigger event |
| trig_out | output | 1 | Latched trigger level with chosen polarity |

## Verification
The pulse is due one clock after the edge at which the final stage matches. `trig_out` changes in that same cycle and changes back in the cycle after the arm edge. The stage index advances at every matching edge, so an N-stage chain with all conditions matching needs N evaluated edges after the arm edge.

Every scenario drives its inputs on the falling edge and reads the outputs on the next falling edge. Each read therefore reflects exactly one evaluated sample. Edge cases such as the first sample after arming are checked at that exact edge, not within a window.

// File: rtl/mlt_trigger_pkg.sv
package mlt_trigger_pkg;

    typedef enum logic [2:0] {
        C_ANY  = 3'd0,
        C_LOW  = 3'd1,
        C_HIGH = 3'd2,
        C_RISE = 3'd3,
        C_FALL = 3'd4,
        C_EDGE = 3'd5
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FIRED  = 2'd2
    } state_e;

    localparam int COND_W = 3;

    function automatic logic cond_hit(input logic [COND_W-1:0] code,
                                      input logic cur,
                                      input logic prv,
                                      input logic prv_ok);
        logic r;
        case (code)
            C_ANY:   r = 1'b1;
            C_LOW:   r = ~cur;
            C_HIGH:  r = cur;
            C_RISE:  r = prv_ok & ~prv & cur;
            C_FALL:  r = prv_ok & prv & ~cur;
            C_EDGE:  r = prv_ok & (prv ^ cur);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mlt_stage_match.sv
module mlt_stage_match
    import mlt_trigger_pkg::*;
#(
    parameter int NUM_SIG = 8
) (
    input  logic [NUM_SIG-1:0]        cur,
    input  logic [NUM_SIG-1:0]        prv,
    input  logic                      prv_ok,
    input  logic [NUM_SIG*COND_W-1:0] codes,
    output logic                      hit
);

    logic [NUM_SIG-1:0] sig_ok;

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        assign sig_ok[s] = cond_hit(codes[s*COND_W +: COND_W], cur[s], prv[s], prv_ok);
    end

    assign hit = &sig_ok;

endmodule

// File: rtl/mlt_seq_fsm.sv
module mlt_seq_fsm
    import mlt_trigger_pkg::*;
#(
    parameter int MAX_LVL = 10,
    parameter int LVL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             lvl_ok,
    input  logic [LVL_W-1:0] last_idx,
    output logic [LVL_W-1:0] lvl_idx,
    output logic             prev_ok,
    output logic             fired,
    output logic             trig_pulse
);

    state_e           state, state_nx;
    logic [LVL_W-1:0] lvl_nx;

    always_comb begin
        state_nx = state;
        lvl_nx   = lvl_idx;
        unique case (state)
            ST_IDLE: begin
                if (arm) begin
                    state_nx = ST_SEARCH;
                    lvl_nx   = '0;
                end
            end
            ST_SEARCH: begin
                if (arm) begin
                    lvl_nx = '0;
                end else if (lvl_ok) begin
                    if (lvl_idx == last_idx) state_nx = ST_FIRED;
                    else                     lvl_nx   = lvl_idx + 1'b1;
                end
            end
            ST_FIRED: begin
                if (arm) begin
                    state_nx = ST_SEARCH;
                    lvl_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                lvl_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl_idx <= '0;
        end else begin
            state   <= state_nx;
            lvl_idx <= lvl_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            prev_ok    <= 1'b0;
        end else begin
            trig_pulse <= (state == ST_SEARCH) && (state_nx == ST_FIRED);
            if (arm)                     prev_ok <= 1'b0;
            else if (state == ST_SEARCH) prev_ok <= 1'b1;
        end
    end

    assign fired = (state == ST_FIRED);

    // R1
    fire_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && !arm && lvl_ok && lvl_idx == last_idx) |=> trig_pulse);

    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R7
    fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRED && !arm) |=> (state == ST_FIRED && !trig_pulse));

    // R5
    lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && !arm && lvl_ok && lvl_idx != last_idx)
        |=> (lvl_idx == $past(lvl_idx) + 1'b1));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE && !trig_pulse));

endmodule

// File: rtl/mlt_trigger_top.sv
module mlt_trigger_top
    import mlt_trigger_pkg::*;
#(
    parameter int NUM_SIG = 8,
    parameter int MAX_LVL = 10,
    localparam int CFG_W  = MAX_LVL * NUM_SIG * COND_W,
    localparam int CNT_W  = $clog2(MAX_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [NUM_SIG-1:0] probe,
    input  logic [CFG_W-1:0]   cond_cfg,
    input  logic [CNT_W-1:0]   lvl_count,
    input  logic               ext_en,
    input  logic               ext_in,
    input  logic [COND_W-1:0]  ext_cond,
    input  logic               trig_pol,
    output logic               trig_pulse,
    output logic               trig_out
);

    localparam int LVL_W = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;
    localparam int STG_W = NUM_SIG * COND_W;

    logic [NUM_SIG-1:0] probe_q;
    logic               ext_q;
    logic               prev_ok;
    logic [MAX_LVL-1:0] stage_hit;
    logic [LVL_W-1:0]   lvl_idx;
    logic [LVL_W-1:0]   last_idx;
    logic               is_last;
    logic               ext_hit;
    logic               lvl_ok;
    logic               fired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_q <= '0;
            ext_q   <= 1'b0;
        end else begin
            probe_q <= probe;
            ext_q   <= ext_in;
        end
    end

    always_comb begin
        if (lvl_count == '0)
            last_idx = '0;
        else if (lvl_count > CNT_W'(MAX_LVL))
            last_idx = LVL_W'(MAX_LVL - 1);
        else
            last_idx = LVL_W'(lvl_count - CNT_W'(1));
    end

    for (genvar l = 0; l < MAX_LVL; l++) begin : g_stage
        mlt_stage_match #(.NUM_SIG(NUM_SIG)) u_stage (
            .cur    (probe),
            .prv    (probe_q),
            .prv_ok (prev_ok),
            .codes  (cond_cfg[l*STG_W +: STG_W]),
            .hit    (stage_hit[l])
        );
    end

    assign is_last = (lvl_idx == last_idx);
    assign ext_hit = cond_hit(ext_cond, ext_in, ext_q, prev_ok);
    assign lvl_ok  = stage_hit[lvl_idx] && (!(is_last && ext_en) || ext_hit);

    mlt_seq_fsm #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .lvl_ok     (lvl_ok),
        .last_idx   (last_idx),
        .lvl_idx    (lvl_idx),
        .prev_ok    (prev_ok),
        .fired      (fired),
        .trig_pulse (trig_pulse)
    );

    assign trig_out = fired ~^ trig_pol;

    // R8
    pol_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (trig_out == trig_pol));

    // R4
    first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_ok && ext_cond == C_RISE) |-> !ext_hit);

endmodule

// File: tb/mlt_trigger_top_tb.sv
module mlt_trigger_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 8;
    localparam int NL  = 10;
    localparam int CFW = NL * NS * 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic [NS-1:0]  probe = '0;
    logic [CFW-1:0] cfg = '0;
    logic [3:0]     lvl_count = 4'd1;
    logic           ext_en = 1'b0;
    logic           ext_in = 1'b0;
    logic [2:0]     ext_cond = 3'd0;
    logic           trig_pol = 1'b1;
    logic           trig_pulse;
    logic           trig_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlt_trigger_top #(.NUM_SIG(NS), .MAX_LVL(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cond_cfg(cfg),
        .lvl_count(lvl_count), .ext_en(ext_en), .ext_in(ext_in),
        .ext_cond(ext_cond), .trig_pol(trig_pol),
        .trig_pulse(trig_pulse), .trig_out(trig_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic setc(input int l, input int s, input logic [2:0] c);
        cfg[(l*NS+s)*3 +: 3] = c;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        tick();
        arm = 1'b0;
    endtask

    task automatic t_reset();
        cfg = '0; lvl_count = 4'd1;
        chk(trig_pulse, 1'b0, "R11 reset pulse");
        chk(trig_out, 1'b0, "R11 reset trig_out");
        rst_n = 1'b1;
        repeat (3) tick();
        chk(trig_pulse, 1'b0, "R11 unarmed no trigger");
        chk(trig_out, 1'b0, "R8 unarmed trig_out inactive");
    endtask

    task automatic t_static();
        cfg = '0; lvl_count = 4'd1;
        setc(0, 1, 3'd2); setc(0, 4, 3'd1);
        probe = 8'h10;
        do_arm();
        chk(trig_pulse, 1'b0, "R1 no pulse at arm edge");
        tick();
        chk(trig_pulse, 1'b0, "R2 low/high not met");
        probe = 8'h02;
        tick();
        chk(trig_pulse, 1'b1, "R1 R2 pulse one cycle after match");
        chk(trig_out, 1'b1, "R8 trig_out active after fire");
        tick();
        chk(trig_pulse, 1'b0, "R1 pulse lasts one cycle");
    endtask

    task automatic t_edge_after_arm();
        cfg = '0; lvl_count = 4'd1;
        setc(0, 0, 3'd3);
        probe = 8'h00;
        do_arm();
        probe = 8'h01;
        tick();
        chk(trig_pulse, 1'b0, "R4 no edge on first sample");
        tick();
        chk(trig_pulse, 1'b0, "R3 steady high is not rising");
        probe = 8'h00; tick();
        chk(trig_pulse, 1'b0, "R3 falling is not rising");
        probe = 8'h01; tick();
        chk(trig_pulse, 1'b1, "R3 rising edge fires");
    endtask

    task automatic t_order();
        cfg = '0; lvl_count = 4'd3;
        setc(0, 1, 3'd2); setc(1, 2, 3'd4); setc(2, 3, 3'd5);
        probe = 8'h04;
        do_arm();
        tick();
        probe = 8'h00; tick();
        chk(trig_pulse, 1'b0, "R5 later stage fall ignored early");
        probe = 8'h06; tick();
        chk(trig_pulse, 1'b0, "R5 stage0 met only");
        probe = 8'h02; tick();
        chk(trig_pulse, 1'b0, "R3 R5 stage1 falling met");
        probe = 8'h0A; tick();
        chk(trig_pulse, 1'b1, "R3 R5 stage2 either edge fires");
    endtask

    task automatic t_latch();
        tick(); tick(); tick();
        chk(trig_pulse, 1'b0, "R7 no pulse while latched");
        chk(trig_out, 1'b1, "R8 trig_out held until re-arm");
        do_arm();
        chk(trig_out, 1'b0, "R8 trig_out cleared by arm");
    endtask

    task automatic t_chain(input logic [3:0] cnt, input int expect_at, input string req);
        cfg = '0; lvl_count = cnt; probe = 8'h00;
        do_arm();
        for (int i = 1; i <= expect_at; i++) begin
            tick();
            if (i == expect_at) chk(trig_pulse, 1'b1, req);
            else if (trig_pulse !== 1'b0) chk(trig_pulse, 1'b0, req);
        end
        checks++;
    endtask

    task automatic t_polarity();
        trig_pol = 1'b0;
        cfg = '0; lvl_count = 4'd1;
        setc(0, 5, 3'd2);
        probe = 8'h00;
        do_arm();
        tick();
        chk(trig_out, 1'b1, "R8 active-low idle level");
        probe = 8'h20; tick();
        chk(trig_out, 1'b0, "R8 active-low asserted");
        trig_pol = 1'b1;
    endtask

    task automatic t_ext();
        cfg = '0; lvl_count = 4'd1;
        setc(0, 0, 3'd2);
        ext_en = 1'b1; ext_cond = 3'd2; ext_in = 1'b0;
        probe = 8'h01;
        do_arm();
        tick();
        chk(trig_pulse, 1'b0, "R9 ext not met blocks");
        ext_in = 1'b1; tick();
        chk(trig_pulse, 1'b1, "R9 ext met fires");
        ext_en = 1'b0; ext_in = 1'b0;
        do_arm();
        tick();
        chk(trig_pulse, 1'b1, "R9 ext ignored when disabled");
    endtask

    task automatic t_reserved();
        cfg = '0; lvl_count = 4'd1;
        setc(0, 0, 3'd6); setc(0, 1, 3'd7);
        probe = 8'h00;
        do_arm();
        for (int i = 0; i < 4; i++) begin
            probe = 8'(i); tick();
        end
        chk(trig_pulse, 1'b0, "R10 reserved codes never match");
        chk(trig_out, 1'b0, "R10 no latched trigger");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_static();
        t_edge_after_arm();
        t_order();
        t_latch();
        t_chain(4'd10, 10, "R6 ten stages fire on tenth sample");
        t_chain(4'd0, 1, "R6 count zero acts as one");
        t_chain(4'd15, 10, "R6 count above ten acts as ten");
        t_polarity();
        t_ext();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule